// File: doc/BRIEF.md
# Streaming Vector-Matrix Multiplier

This block multiplies a row vector of N signed elements by an N×N signed matrix and streams out the N elements of the product, one at a time. The vector is written element by element in natural order into a circular store. The matrix is written already transposed, so each stored row holds one column of the original matrix. A load counter steers each group of N matrix writes into the next row store. Once both operands are loaded, a start pulse launches the computation. A single multiply-accumulate datapath walks the circulating vector against the currently selected row, one product per cycle. A row select then moves to the next row, so the whole multiply runs as N dot products back to back.

Every store rotates by one position for each product it supplies, and after N products it is back in its original alignment. The operands therefore survive a computation unchanged, and the same data can be multiplied again without reloading. Each result carries its index and appears with a single-cycle valid pulse.

Top module: `vecmat_stream`

## Requirements
- R1: After reset, `busy`, `res_valid` and `res_idx` are all zero.
- R2: While idle, the k-th `vec_wr` write since the vector was last filled becomes vector element k (k = 0..N-1). Each write shifts the store, so the last N writes define the vector.
- R3: While idle, matrix write number r*N+c (counted modulo N*N from reset) stores element c of stored row r. The row pointer advances after every N writes and wraps from N-1 to 0. The host writes original element M[c][r] there, so stored row r is column r of M.
- R4: Result element i equals the sum over j of v[j]*M[j][i], computed signed at full width (ACC_W = 2*W + clog2(N) bits) so that it never overflows.
- R5: A `start` sampled while idle makes `busy` high from the next cycle. With the start sampled at edge E0, result i is presented after edge E(N*(i+1)).
- R6: Exactly N results are produced per start, in index order 0..N-1, with `res_idx` equal to the index. Each `res_valid` is a single-cycle pulse.
- R7: `busy` falls together with the presentation of result N-1. The row select wraps, so the next start begins again at row 0.
- R8: The stored operands recirculate, so a second start without reloading yields identical results.
- R9: While `busy` is high, `vec_wr`, `mat_wr` and `start` are ignored. They neither change the results in progress, nor the stored operands, nor the matrix load position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_wr | input | 1 | Write one vector element (idle only) |
| vec_din | input | W | Signed vector element |
| mat_wr | input | 1 | Write one transposed-matrix element (idle only) |
| mat_din | input | W | Signed matrix element |
| start | input | 1 | Begin a multiply (idle only) |
| busy | output | 1 | Computation in progress |
| res_valid | output | 1 | One-cycle strobe for a result element |
| res_data | output | 2*W+clog2(N) | Signed result element |
| res_idx | output | clog2(N) | Index of the result element |

## Verification
An identity matrix with a ramp vector exposes any misordering of vector elements. A matrix of distinct values with mixed-sign vector entries separates transposed storage from straight storage, because swapping rows and columns changes every output. Operands that are all the most negative value push the sum to 2^64 and test sign handling and the full accumulator width. Random full-range operands, repeated starts without reloading, and writes and start pulses injected mid-computation check recirculation and the rule that inputs are ignored while busy.

// File: rtl/vecmat_stream.sv
module vecmat_stream #(
  parameter int N = 4,
  parameter int W = 32,
  localparam int CW = $clog2(N),
  localparam int ACC_W = 2 * W + CW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vec_wr,
  input  logic signed [W-1:0]     vec_din,
  input  logic                    mat_wr,
  input  logic signed [W-1:0]     mat_din,
  input  logic                    start,
  output logic                    busy,
  output logic                    res_valid,
  output logic signed [ACC_W-1:0] res_data,
  output logic [CW-1:0]           res_idx
);

  logic signed [W-1:0] vreg [N];
  logic signed [W-1:0] mreg [N][N];

  logic [CW-1:0] k, sel, lrow, lcol;
  logic signed [ACC_W-1:0] acc;

  logic signed [2*W-1:0]   prod;
  logic signed [ACC_W-1:0] sum;
  logic                    last_k, last_row, last_col;

  assign prod     = vreg[0] * mreg[sel][0];
  assign sum      = acc + {{CW{prod[2*W-1]}}, prod};
  assign last_k   = (k == CW'(N - 1));
  assign last_row = (sel == CW'(N - 1));
  assign last_col = (lcol == CW'(N - 1));

  always_ff @(posedge clk) begin
    if (vec_wr && !busy) begin
      vreg[N-1] <= vec_din;
      for (int i = 0; i < N - 1; i++) vreg[i] <= vreg[i+1];
    end else if (busy) begin
      vreg[N-1] <= vreg[0];
      for (int i = 0; i < N - 1; i++) vreg[i] <= vreg[i+1];
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (mat_wr && !busy && lrow == CW'(r)) begin
        mreg[r][N-1] <= mat_din;
        for (int i = 0; i < N - 1; i++) mreg[r][i] <= mreg[r][i+1];
      end else if (busy && sel == CW'(r)) begin
        mreg[r][N-1] <= mreg[r][0];
        for (int i = 0; i < N - 1; i++) mreg[r][i] <= mreg[r][i+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      k         <= '0;
      sel       <= '0;
      lrow      <= '0;
      lcol      <= '0;
      acc       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_idx   <= '0;
    end else begin
      res_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          k    <= '0;
          sel  <= '0;
          acc  <= '0;
        end
        if (mat_wr) begin
          lcol <= last_col ? '0 : lcol + 1'b1;
          if (last_col) lrow <= (lrow == CW'(N - 1)) ? '0 : lrow + 1'b1;
        end
      end else if (last_k) begin
        res_valid <= 1'b1;
        res_data  <= sum;
        res_idx   <= sel;
        acc       <= '0;
        k         <= '0;
        if (last_row) begin
          sel  <= '0;
          busy <= 1'b0;
        end else begin
          sel <= sel + 1'b1;
        end
      end else begin
        acc <= sum;
        k   <= k + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vecmat_stream_chk.sv
module vecmat_stream_chk #(
  parameter int N = 4,
  localparam int CW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          res_valid,
  input logic [CW-1:0] res_idx
);

  logic [CW-1:0] seen_idx;
  logic          seen_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_idx <= '0;
      seen_any <= 1'b0;
    end else if (res_valid) begin
      seen_idx <= res_idx;
      seen_any <= 1'b1;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R6

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R5

  AST_END_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (res_valid && res_idx == CW'(N - 1))); // R7

  AST_MID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_idx != CW'(N - 1)) |-> busy); // R7

  AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && seen_any && res_idx != '0) |-> (res_idx == seen_idx + 1'b1)); // R6

  AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !seen_any) |-> (res_idx == '0)); // R6

endmodule

bind vecmat_stream vecmat_stream_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .res_valid(res_valid), .res_idx(res_idx)
);

// File: tb/vecmat_stream_test.sv
module vecmat_stream_test;
  localparam int N = 4;
  localparam int W = 32;
  localparam int CW = $clog2(N);
  localparam int ACC_W = 2 * W + CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vec_wr = 1'b0, mat_wr = 1'b0, start = 1'b0;
  logic signed [W-1:0] vec_din = '0, mat_din = '0;
  logic busy, res_valid;
  logic signed [ACC_W-1:0] res_data;
  logic [CW-1:0] res_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic signed [W-1:0] tv [N];
  logic signed [W-1:0] tm [N][N];

  always #2 clk = ~clk;

  vecmat_stream #(.N(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .vec_wr(vec_wr), .vec_din(vec_din),
    .mat_wr(mat_wr), .mat_din(mat_din), .start(start), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .res_idx(res_idx)
  );

  task automatic check(input bit ok, input string msg,
                       input logic signed [ACC_W-1:0] act,
                       input logic signed [ACC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  function automatic logic signed [ACC_W-1:0] expect_elem(input int i);
    logic signed [ACC_W-1:0] s = '0;
    for (int j = 0; j < N; j++) begin
      logic signed [2*W-1:0] p = tv[j] * tm[j][i];
      s = s + ACC_W'(p);
    end
    return s;
  endfunction

  task automatic load_all();
    for (int j = 0; j < N; j++) begin
      @(negedge clk); vec_wr = 1'b1; vec_din = tv[j];
    end
    @(negedge clk); vec_wr = 1'b0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        @(negedge clk); mat_wr = 1'b1; mat_din = tm[c][r];
      end
    @(negedge clk); mat_wr = 1'b0;
  endtask

  task automatic run(input bit disturb, input string tag);
    logic signed [ACC_W-1:0] exp [N];
    int got = 0;
    for (int i = 0; i < N; i++) exp[i] = expect_elem(i);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, {"R5 busy after start ", tag}, busy, 1);
    for (int c = 0; c <= N * N + 2; c++) begin
      if (c > 0) @(negedge clk);
      if (disturb && c == 2) begin
        vec_wr = 1'b1; vec_din = 32'sh5A5A5A5A;
        mat_wr = 1'b1; mat_din = -32'sd7; start = 1'b1;
      end
      if (disturb && c == 3) begin
        vec_wr = 1'b0; mat_wr = 1'b0; start = 1'b0;
      end
      if (res_valid) begin
        check(got < N, {"R6 result count ", tag}, got, N - 1);
        if (got < N) begin
          check(res_idx == CW'(got), {"R6 index order ", tag}, res_idx, got);
          check(res_data == exp[got], {"R4/R9 result value ", tag}, res_data, exp[got]);
          check(c == N * (got + 1), {"R5 result timing ", tag}, c, N * (got + 1));
        end
        got++;
      end
    end
    check(got == N, {"R6 results per start ", tag}, got, N);
    check(busy == 1'b0, {"R7 idle after last ", tag}, busy, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy at reset", busy, 0);
    check(res_valid == 1'b0, "R1 valid at reset", res_valid, 0);
    check(res_idx == '0, "R1 idx at reset", res_idx, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: identity matrix with a ramp vector
    for (int j = 0; j < N; j++) begin
      tv[j] = j + 1;
      for (int i = 0; i < N; i++) tm[j][i] = (i == j) ? 1 : 0;
    end
    load_all();
    run(1'b0, "identity R2");

    // R3: distinct entries, mixed signs
    for (int j = 0; j < N; j++) begin
      tv[j] = (j % 2 == 0) ? -(j + 3) : (j + 5);
      for (int i = 0; i < N; i++) tm[j][i] = j * 10 + i * 3 + 1;
    end
    load_all();
    run(1'b0, "transposed R3");
    run(1'b0, "rerun R8 R7");
    run(1'b1, "disturbed R9");
    run(1'b0, "after disturb R9");

    // R4: extreme magnitudes
    for (int j = 0; j < N; j++) begin
      tv[j] = 32'sh80000000;
      for (int i = 0; i < N; i++) tm[j][i] = (i == 1) ? 32'sh7FFFFFFF : 32'sh80000000;
    end
    load_all();
    run(1'b0, "extreme R4");

    for (int t = 0; t < 4; t++) begin
      for (int j = 0; j < N; j++) begin
        tv[j] = $signed($urandom);
        for (int i = 0; i < N; i++) tm[j][i] = $signed($urandom);
      end
      load_all();
      run(t == 2, "random R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule